// File: doc/BRIEF.md
# Remote DMA Data Port

This block sits between a host data port and a network controller's local buffer RAM. A host access to the data port reads or writes one, two or four bytes at the current remote address. The remote address and the remaining byte count are held here. After each access the address moves forward by the number of bytes moved, and it wraps from the ring's stop address back to its start address. The count goes down by the same amount. When the count runs out, a one-cycle completion pulse goes to the interrupt status logic.

Only two local regions can be reached: the station address area at the bottom of the map, and the packet memory window. A write outside these regions is dropped. A read outside them returns all ones at the access width. Data has a fixed one-cycle RAM latency, and a ready strobe marks the cycle in which read data is valid. The RAM array, the host bus decode and the register file that programs the ring limits are outside this block.

Top module: `rdma_port`

## Requirements
- R1: The width of an access is set as follows. When `acc_quad_i`=1, four bytes move. Otherwise `cfg_wide_i`=1 moves two bytes and `cfg_wide_i`=0 moves one byte.
- R2: After an accepted access, the address equals the address before the access plus the byte count n. If that sum equals `ring_stop_i`, the address becomes `ring_start_i` instead.
- R3: After an accepted access with remaining count <= n, the count becomes 0 and `dma_done_o` is high for exactly the next cycle. Otherwise the count drops by n. Reads are accepted even when the count is 0.
- R4: A write while the count is 0 is ignored. There is no RAM request, the address and count do not change, and there is no done pulse.
- R5: Let base be the access address, with bit 0 cleared for 2- and 4-byte accesses. The access is valid when base < 32, or when base >= `PMEM_LO` and base+n <= `MEM_TOP` (defaults 0x4000 and 0xC000). An invalid access makes no RAM request, but the address and count still update.
- R6: An invalid read returns 0xFF, 0xFFFF or 0xFFFFFFFF according to its width. A valid 1- or 2-byte read is zero-extended to 32 bits.
- R7: For 2- and 4-byte accesses, RAM address bit 0 is forced to 0. Data is little-endian: byte lane k (bits 8k+7:8k) maps to base+k, and `ram_be_o` is 0001, 0011 or 1111.
- R8: `rd_ready_o` is high for exactly one cycle, the cycle after a read is accepted, and `rd_data_o` is valid in that cycle.
- R9: A pulse on `ld_addr_we_i` or `ld_cnt_we_i` loads the address or count, and the new value is visible in the next cycle. A data-port access in the same cycle as either load is dropped entirely.
- R10: After reset the address and count are 0, and `rd_ready_o` and `dma_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wide_i | input | 1 | 1: narrow accesses move two bytes |
| ring_start_i | input | 16 | Ring start byte address |
| ring_stop_i | input | 16 | Ring stop byte address |
| ld_addr_we_i | input | 1 | Load remote address |
| ld_addr_i | input | 16 | Remote address load value |
| ld_cnt_we_i | input | 1 | Load remaining count |
| ld_cnt_i | input | 16 | Count load value |
| acc_valid_i | input | 1 | Data port access strobe |
| acc_write_i | input | 1 | 1: write, 0: read |
| acc_quad_i | input | 1 | 1: four-byte access |
| acc_wdata_i | input | 32 | Write data, little-endian lanes |
| rd_ready_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data |
| dma_done_o | output | 1 | Count exhausted pulse |
| cur_addr_o | output | 16 | Current remote address |
| cur_cnt_o | output | 16 | Remaining count |
| ram_en_o | output | 1 | RAM request |
| ram_we_o | output | 1 | RAM write |
| ram_addr_o | output | 16 | RAM byte address |
| ram_be_o | output | 4 | RAM byte enables |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, one cycle after request |

## Verification
The RAM request appears in the same cycle the access strobe is sampled. The new address, count and done pulse show one cycle after that edge. Read data and its ready strobe arrive one cycle after the edge as well, because of the RAM latency. The bench drives on falling edges and checks the address, count and done at the falling edge that follows the accepting edge. A monitor on falling edges pops the queue of expected read words whenever ready is high, and it flags a ready that arrives without an expected word.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    XW_BYTE = 2'd0,
    XW_HALF = 2'd1,
    XW_WORD = 2'd2
  } xfer_w_e;
endpackage

// File: rtl/rdma_width_sel.sv
module rdma_width_sel
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          wide_i,
  input  logic          quad_i,
  input  logic [AW-1:0] addr_i,
  output xfer_w_e       xw_o,
  output logic [2:0]    nbytes_o,
  output logic [AW-1:0] base_o,
  output logic [3:0]    be_o
);
  always_comb begin
    if (quad_i)      xw_o = XW_WORD;
    else if (wide_i) xw_o = XW_HALF;
    else             xw_o = XW_BYTE;
    unique case (xw_o)
      XW_WORD: begin nbytes_o = 3'd4; be_o = 4'b1111; end
      XW_HALF: begin nbytes_o = 3'd2; be_o = 4'b0011; end
      default: begin nbytes_o = 3'd1; be_o = 4'b0001; end
    endcase
    base_o = (xw_o == XW_BYTE) ? addr_i : {addr_i[AW-1:1], 1'b0};
  end
endmodule

// File: rtl/rdma_win_chk.sv
module rdma_win_chk #(
  parameter int AW          = 16,
  parameter int STATION_TOP = 32,
  parameter int PMEM_LO     = 16384,
  parameter int MEM_TOP     = 49152
) (
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    nbytes_i,
  output logic          ok_o
);
  localparam int EW = AW + 1;
  logic [EW-1:0] end_w;
  assign end_w = {1'b0, base_i} + EW'(nbytes_i);
  assign ok_o = (EW'(base_i) < EW'(STATION_TOP)) ||
                ((EW'(base_i) >= EW'(PMEM_LO)) && (end_w <= EW'(MEM_TOP)));
endmodule

// File: rtl/rdma_ptr_ctr.sv
module rdma_ptr_ctr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_addr_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_cnt_we_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          step_i,
  input  logic [2:0]    nbytes_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] stop_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic [AW:0]   sum;
  logic          last;
  assign sum  = {1'b0, addr_o} + (AW+1)'(nbytes_i);
  assign last = cnt_o <= CW'(nbytes_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (ld_addr_we_i || ld_cnt_we_i) begin
        if (ld_addr_we_i) addr_o <= ld_addr_i;
        if (ld_cnt_we_i)  cnt_o  <= ld_cnt_i;
      end else if (step_i) begin
        addr_o <= (sum == {1'b0, stop_i}) ? start_i : sum[AW-1:0];
        cnt_o  <= last ? '0 : cnt_o - CW'(nbytes_i);
        done_o <= last;
      end
    end
  end
endmodule

// File: rtl/rdma_rd_ret.sv
module rdma_rd_ret
  import rdma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        issue_i,
  input  xfer_w_e     xw_i,
  input  logic        ok_i,
  input  logic [31:0] ram_rdata_i,
  output logic        ready_o,
  output logic [31:0] data_o
);
  xfer_w_e     xw_q;
  logic        ok_q;
  logic [31:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      xw_q    <= XW_BYTE;
      ok_q    <= 1'b0;
    end else begin
      ready_o <= issue_i;
      if (issue_i) begin
        xw_q <= xw_i;
        ok_q <= ok_i;
      end
    end
  end

  always_comb begin
    unique case (xw_q)
      XW_WORD: mask = 32'hFFFF_FFFF;
      XW_HALF: mask = 32'h0000_FFFF;
      default: mask = 32'h0000_00FF;
    endcase
    data_o = ok_q ? (ram_rdata_i & mask) : mask;
  end
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CW          = 16,
  parameter int STATION_TOP = 32,
  parameter int PMEM_LO     = 16384,
  parameter int MEM_TOP     = 49152
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wide_i,
  input  logic [AW-1:0] ring_start_i,
  input  logic [AW-1:0] ring_stop_i,
  input  logic          ld_addr_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic          ld_cnt_we_i,
  input  logic [CW-1:0] ld_cnt_i,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic          acc_quad_i,
  input  logic [31:0]   acc_wdata_i,
  output logic          rd_ready_o,
  output logic [31:0]   rd_data_o,
  output logic          dma_done_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [3:0]    ram_be_o,
  output logic [31:0]   ram_wdata_o,
  input  logic [31:0]   ram_rdata_i
);
  xfer_w_e       xw;
  logic [2:0]    nbytes;
  logic [AW-1:0] base;
  logic          win_ok;
  logic          acc_go;

  rdma_width_sel #(.AW(AW)) u_wsel (
    .wide_i(cfg_wide_i), .quad_i(acc_quad_i), .addr_i(cur_addr_o),
    .xw_o(xw), .nbytes_o(nbytes), .base_o(base), .be_o(ram_be_o)
  );

  rdma_win_chk #(.AW(AW), .STATION_TOP(STATION_TOP), .PMEM_LO(PMEM_LO),
                 .MEM_TOP(MEM_TOP)) u_win (
    .base_i(base), .nbytes_i(nbytes), .ok_o(win_ok)
  );

  // loads win over the data port; writes need a live count
  assign acc_go = acc_valid_i && !(ld_addr_we_i || ld_cnt_we_i) &&
                  !(acc_write_i && (cur_cnt_o == '0));

  assign ram_en_o    = acc_go && win_ok;
  assign ram_we_o    = acc_write_i;
  assign ram_addr_o  = base;
  assign ram_wdata_o = acc_wdata_i;

  rdma_ptr_ctr #(.AW(AW), .CW(CW)) u_ptr (
    .clk_i, .rst_ni,
    .ld_addr_we_i, .ld_addr_i, .ld_cnt_we_i, .ld_cnt_i,
    .step_i(acc_go), .nbytes_i(nbytes),
    .start_i(ring_start_i), .stop_i(ring_stop_i),
    .addr_o(cur_addr_o), .cnt_o(cur_cnt_o), .done_o(dma_done_o)
  );

  rdma_rd_ret u_ret (
    .clk_i, .rst_ni,
    .issue_i(acc_go && !acc_write_i), .xw_i(xw), .ok_i(win_ok),
    .ram_rdata_i, .ready_o(rd_ready_o), .data_o(rd_data_o)
  );
endmodule

// File: rtl/rdma_port_chk.sv
module rdma_port_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] ring_start_i,
  input logic [AW-1:0] ring_stop_i,
  input logic          ld_addr_we_i,
  input logic          ld_cnt_we_i,
  input logic          acc_valid_i,
  input logic          acc_write_i,
  input logic          acc_quad_i,
  input logic          cfg_wide_i,
  input logic          rd_ready_o,
  input logic          dma_done_o,
  input logic [AW-1:0] cur_addr_o,
  input logic [CW-1:0] cur_cnt_o,
  input logic          ram_en_o,
  input logic [AW-1:0] ram_addr_o,
  input logic [3:0]    ram_be_o
);
  logic ld_any;
  assign ld_any = ld_addr_we_i || ld_cnt_we_i;

  a_r4_no_write_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && (cur_cnt_o == '0) |-> !ram_en_o);

  a_r4_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && (cur_cnt_o == '0) && !ld_any
    |=> $stable(cur_addr_o) && !dma_done_o);

  a_r8_ready_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i && !ld_any |=> rd_ready_o);

  a_r8_no_spurious_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_valid_i && !acc_write_i) |=> !rd_ready_o);

  a_r3_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_o |-> cur_cnt_o == '0);

  a_r2_never_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i && !ld_any && (ring_start_i != ring_stop_i)
    |=> cur_addr_o != $past(ring_stop_i));

  a_r7_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o && (acc_quad_i || cfg_wide_i) |-> !ram_addr_o[0]);

  a_r1_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (ram_be_o == 4'b0001) || (ram_be_o == 4'b0011) ||
                 (ram_be_o == 4'b1111));
endmodule

bind rdma_port rdma_port_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ring_start_i(ring_start_i),
  .ring_stop_i(ring_stop_i), .ld_addr_we_i(ld_addr_we_i),
  .ld_cnt_we_i(ld_cnt_we_i), .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i), .acc_quad_i(acc_quad_i), .cfg_wide_i(cfg_wide_i),
  .rd_ready_o(rd_ready_o), .dma_done_o(dma_done_o), .cur_addr_o(cur_addr_o),
  .cur_cnt_o(cur_cnt_o), .ram_en_o(ram_en_o), .ram_addr_o(ram_addr_o),
  .ram_be_o(ram_be_o)
);

// File: tb/rdma_port_tb.sv
module rdma_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic [15:0] ring_start = 16'h4000, ring_stop = 16'h4100;
  logic        ld_addr_we = 1'b0, ld_cnt_we = 1'b0;
  logic [15:0] ld_addr = '0, ld_cnt = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_quad = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        rd_ready, dma_done, ram_en, ram_we;
  logic [31:0] rd_data, ram_wdata;
  logic [31:0] ram_rdata = '0;
  logic [15:0] cur_addr, cur_cnt, ram_addr;
  logic [3:0]  ram_be;

  int tests = 0, fails = 0, cycles = 0;
  logic [7:0] mem [0:65535];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rdma_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wide_i(cfg_wide),
    .ring_start_i(ring_start), .ring_stop_i(ring_stop),
    .ld_addr_we_i(ld_addr_we), .ld_addr_i(ld_addr),
    .ld_cnt_we_i(ld_cnt_we), .ld_cnt_i(ld_cnt),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_quad_i(acc_quad),
    .acc_wdata_i(acc_wdata), .rd_ready_o(rd_ready), .rd_data_o(rd_data),
    .dma_done_o(dma_done), .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_be_o(ram_be), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  // byte-lane RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin
        for (int k = 0; k < 4; k++)
          if (ram_be[k]) mem[ram_addr + 16'(k)] <= ram_wdata[8*k +: 8];
      end else begin
        ram_rdata <= {mem[ram_addr + 16'd3], mem[ram_addr + 16'd2],
                      mem[ram_addr + 16'd1], mem[ram_addr]};
      end
    end
  end

  function automatic logic [7:0] pre(input logic [15:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected ready", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    @(negedge clk);
    ld_addr_we = 1'b1; ld_addr = a;
    ld_cnt_we  = 1'b1; ld_cnt  = c;
    @(negedge clk);
    ld_addr_we = 1'b0; ld_cnt_we = 1'b0;
  endtask

  // one access; checks address, count and done on the following negedge
  task automatic access(input bit wr, input bit quad, input logic [31:0] wd,
                        input logic [31:0] exp_rd, input string tag,
                        input logic [15:0] exp_addr, input logic [15:0] exp_cnt,
                        input bit exp_done);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_quad = quad; acc_wdata = wd;
    if (!wr) begin exp_q.push_back(exp_rd); tag_q.push_back(tag); end
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_quad = 1'b0;
    chk(cur_addr === exp_addr, {tag, " addr"}, 32'(cur_addr), 32'(exp_addr));
    chk(cur_cnt === exp_cnt, {tag, " count"}, 32'(cur_cnt), 32'(exp_cnt));
    chk(dma_done === exp_done, {tag, " done"}, 32'(dma_done), 32'(exp_done));
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = pre(16'(i));
    #(CLK_PERIOD * 2 + 1);
    // R10 reset state
    chk(cur_addr === 16'd0 && cur_cnt === 16'd0, "R10 regs", {cur_addr, cur_cnt}, 32'd0);
    chk(!rd_ready && !dma_done, "R10 strobes", {30'd0, rd_ready, dma_done}, 32'd0);
    rst_n = 1'b1;

    // R1 byte write, R2 advance, R3 decrement
    load(16'h4000, 16'd5);
    access(1'b1, 1'b0, 32'h0000_00A5, '0, "R1 byte wr", 16'h4001, 16'd4, 1'b0);
    chk(mem[16'h4000] === 8'hA5, "R1 byte data", 32'(mem[16'h4000]), 32'hA5);
    // R7 half write at odd address is aligned, little-endian
    cfg_wide = 1'b1;
    access(1'b1, 1'b0, 32'h0000_BEEF, '0, "R7 half wr", 16'h4003, 16'd2, 1'b0);
    chk({mem[16'h4001], mem[16'h4000]} === 16'hBEEF, "R7 half lanes",
        {mem[16'h4001], mem[16'h4000]}, 32'hBEEF);
    // R3 count exhausted by quad write
    access(1'b1, 1'b1, 32'h1122_3344, '0, "R3 quad wr", 16'h4007, 16'd0, 1'b1);
    chk({mem[16'h4005], mem[16'h4004], mem[16'h4003], mem[16'h4002]} === 32'h1122_3344,
        "R7 quad lanes", {mem[16'h4005], mem[16'h4004], mem[16'h4003], mem[16'h4002]},
        32'h1122_3344);
    // R4 write at zero count ignored
    access(1'b1, 1'b0, 32'h0000_DEAD, '0, "R4 zero wr", 16'h4007, 16'd0, 1'b0);
    chk(mem[16'h4006] === pre(16'h4006), "R4 mem kept", 32'(mem[16'h4006]),
        32'(pre(16'h4006)));
    // R3 read at zero count still proceeds
    cfg_wide = 1'b0;
    access(1'b0, 1'b0, '0, 32'(pre(16'h4007)), "R3 zero rd", 16'h4008, 16'd0, 1'b1);

    // R8/R7 quad read back
    load(16'h4000, 16'd8);
    access(1'b0, 1'b1, '0, 32'h3344_BEEF, "R8 quad rd", 16'h4004, 16'd4, 1'b0);
    // R2 wrap at stop
    cfg_wide = 1'b1;
    load(16'h40FE, 16'd10);
    access(1'b0, 1'b0, '0, {16'd0, pre(16'h40FF), pre(16'h40FE)}, "R2 wrap rd",
           16'h4000, 16'd8, 1'b0);

    // R6 invalid reads
    load(16'h0100, 16'd20);
    cfg_wide = 1'b0;
    access(1'b0, 1'b0, '0, 32'h0000_00FF, "R6 byte inv", 16'h0101, 16'd19, 1'b0);
    cfg_wide = 1'b1;
    access(1'b0, 1'b0, '0, 32'h0000_FFFF, "R6 half inv", 16'h0103, 16'd17, 1'b0);
    access(1'b0, 1'b1, '0, 32'hFFFF_FFFF, "R6 quad inv", 16'h0107, 16'd13, 1'b0);
    // R5 invalid write dropped, address still moves
    cfg_wide = 1'b0;
    load(16'h0100, 16'd3);
    access(1'b1, 1'b0, 32'h0000_0055, '0, "R5 inv wr", 16'h0101, 16'd2, 1'b0);
    chk(mem[16'h0100] === pre(16'h0100), "R5 mem kept", 32'(mem[16'h0100]),
        32'(pre(16'h0100)));
    // R5 station area valid
    load(16'h0010, 16'd4);
    access(1'b1, 1'b0, 32'h0000_0077, '0, "R5 station wr", 16'h0011, 16'd3, 1'b0);
    load(16'h0010, 16'd4);
    access(1'b0, 1'b0, '0, 32'h0000_0077, "R5 station rd", 16'h0011, 16'd3, 1'b0);
    // R5 top edge of packet window
    cfg_wide = 1'b1;
    load(16'hBFFE, 16'd8);
    access(1'b0, 1'b0, '0, {16'd0, pre(16'hBFFF), pre(16'hBFFE)}, "R5 top half",
           16'hC000, 16'd6, 1'b0);
    load(16'hBFFE, 16'd8);
    access(1'b0, 1'b1, '0, 32'hFFFF_FFFF, "R5 top quad over", 16'hC002, 16'd4, 1'b0);

    // R9 access with load in same cycle is dropped
    @(negedge clk);
    ld_cnt_we = 1'b1; ld_cnt = 16'd9;
    acc_valid = 1'b1; acc_write = 1'b0;
    @(negedge clk);
    ld_cnt_we = 1'b0; acc_valid = 1'b0;
    chk(cur_cnt === 16'd9, "R9 count loaded", 32'(cur_cnt), 32'd9);
    chk(cur_addr === 16'hC002, "R9 addr kept", 32'(cur_addr), 32'hC002);
    chk(rd_ready === 1'b0, "R9 no ready", 32'(rd_ready), 32'd0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule